// File: doc/BRIEF.md
# System Control and Memory Banking Register File

This block is the processor-side register file that configures the machine and maps RAM banks into two processor address windows. The processor writes five registers through a small select code: a system configuration register, a display control register, a data-window bank register, a cartridge-window bank register and a read-view switch. It also writes a video mode register, which is stored here. Some registers gate others. The data-bank register carries a lock that blocks writes to the video mode register. Writes to the cartridge-bank register are accepted only while cartridge banking is enabled in the system configuration register.

Reads return one of two views, chosen by a single switch bit. In one view every read returns the lightpen value supplied by the neighbouring lightpen block. In the other view, reads return the readable part of this block's own state. The block also translates a processor address into a physical RAM address. The bank number from the register that owns the matching window supplies the upper bits. One bit marks which 8 KB half of the bank is addressed. The two windows see the halves in opposite order, so the lower half of the cartridge window is the upper half of the data window.

All outputs are registered. Configuration outputs change on the clock edge after the write. Read data and the address translation appear one cycle after their inputs are presented.

Top module: `sysctl_bank_regs`

## Requirements
- R1: A synchronous active-high reset clears every register. After reset, all configuration outputs, `rd_data`, `map_hit`, `map_wr_ok`, `phys_addr` and `vmode_we` are 0, and the extended read view is selected.
- R2: A write with `reg_sel`=3 loads the system register on the next edge. Bit 7 drives `ext_fdc`, bit 6 drives `cart_bank_en`, bit 5 drives `lines525`, bit 4 drives `data_bank_en`, bits 3:2 drive `machine_type` and bits 1:0 drive `ram_type`.
- R3: A write with `reg_sel`=4 loads the display register. Bits 7:6 drive `disp_page`, bit 5 drives `cart_off`, bit 4 drives `rom_sel` and bits 3:0 drive `border`.
- R4: A write with `reg_sel`=1 stores bits 4:0 as the data bank and bit 7 as the video-mode lock. Bits 6:5 are discarded. An extended read of select 1 returns {3'b000, bank}.
- R5: A write with `reg_sel`=5 pulses `vmode_we` for one cycle and loads `vmode_data`, unless the lock is set. While the lock is set, such a write leaves `vmode_we` at 0 and `vmode_data` unchanged.
- R6: A write with `reg_sel`=2 is ignored unless `cart_bank_en` is 1. When it is accepted, bit 6 drives `cart_wr_en`, bit 5 drives `cart_ram_sel`, bits 4:0 hold the cartridge bank, and bit 7 is stored as 0. An extended read of select 2 returns {0, cart_wr_en, cart_ram_sel, bank}.
- R7: Bit 0 of a write with `reg_sel`=0 sets the read view. When it is 1, a read returns `pen_data` one cycle after `rd_en`. When `rd_en` is low, `rd_data` is 0 on the next cycle.
- R8: In the extended view (view bit 0), a read of select 0 returns {display bits 7:4, 4'b0000}. Selects 3, 4, 5, 6 and 7 read as 0.
- R9: When `data_bank_en` is 1 and `cpu_addr` is in 0xA000–0xDFFF, the next cycle shows `map_hit`=1, `map_wr_ok`=1 and `phys_addr` = {data bank, NOT offset bit 13, offset bits 12:0}, where the offset is `cpu_addr`−0xA000.
- R10: When `cart_bank_en` and `cart_ram_sel` are both 1 and `cpu_addr` is in 0x0000–0x3FFF, the next cycle shows `map_hit`=1, `map_wr_ok`=`cart_wr_en` and `phys_addr` = {cartridge bank, address bit 13, address bits 12:0}.
- R11: Otherwise, `map_hit`, `map_wr_ok` and `phys_addr` are all 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select code |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| pen_data | input | 8 | Lightpen value for the lightpen read view |
| rd_data | output | 8 | Registered read data |
| cpu_addr | input | 16 | Processor address to translate |
| map_hit | output | 1 | Address falls in an enabled banked window |
| map_wr_ok | output | 1 | Write permitted to the mapped RAM |
| phys_addr | output | 19 | Physical RAM address {bank, half, offset} |
| ext_fdc | output | 1 | Internal floppy controller disabled |
| lines525 | output | 1 | 525-line frame when 1, 625 when 0 |
| cart_bank_en | output | 1 | Cartridge-window banking enabled |
| data_bank_en | output | 1 | Data-window banking enabled |
| machine_type | output | 2 | Machine type code |
| ram_type | output | 2 | RAM chip type code |
| disp_page | output | 2 | RAM page shown on screen |
| cart_off | output | 1 | Cartridge disable |
| rom_sel | output | 1 | ROM variant select |
| border | output | 4 | Border colour index |
| cart_wr_en | output | 1 | Write enable for cartridge-window RAM |
| cart_ram_sel | output | 1 | RAM instead of ROM in the cartridge window |
| vmode_we | output | 1 | One-cycle video mode write pulse |
| vmode_data | output | 8 | Stored video mode value |

## Verification
The bench first writes every register with patterns that set all bits, including the bits that must be discarded. This separates correct field extraction from stored garbage. It then writes the gated registers twice, once with the gate closed and once with it open, so that a missing or inverted gate shows up as a mismatch. The address translation is exercised with the exact edges of both windows and with pseudo-random addresses. These are repeated with banking fully enabled, with the cartridge window on ROM, and with banking off. This exposes range, half-swap and enable errors. Reads alternate between the two views to show that the switch, and not the select code, chooses the source.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int SEL_W = 3;
  localparam int DW    = 8;

  localparam logic [SEL_W-1:0] SEL_SWITCH = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DBANK  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CBANK  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_SYS    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DISP   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_VMODE  = 3'd5;

  typedef struct packed {
    logic       ext_fdc;
    logic       cart_bank_en;
    logic       lines525;
    logic       data_bank_en;
    logic [1:0] machine;
    logic [1:0] ram_type;
  } sys_cfg_t;

  typedef struct packed {
    logic [1:0] page;
    logic       cart_off;
    logic       rom_sel;
    logic [3:0] border;
  } disp_cfg_t;
endpackage

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int BANK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DW-1:0]     wdata,
  output sys_cfg_t          sys_q,
  output disp_cfg_t         disp_q,
  output logic [BANK_W-1:0] dbank_q,
  output logic              lock_q,
  output logic [BANK_W-1:0] cbank_q,
  output logic              cwe_q,
  output logic              cram_q,
  output logic              view_q,
  output logic              vmode_we_q,
  output logic [DW-1:0]     vmode_q
);
  logic wr_sys, wr_disp, wr_dbank, wr_cbank, wr_sw, wr_vm;

  always_comb begin
    wr_sys   = wr_en && (sel == SEL_SYS);
    wr_disp  = wr_en && (sel == SEL_DISP);
    wr_dbank = wr_en && (sel == SEL_DBANK);
    wr_cbank = wr_en && (sel == SEL_CBANK) && sys_q.cart_bank_en;
    wr_sw    = wr_en && (sel == SEL_SWITCH);
    wr_vm    = wr_en && (sel == SEL_VMODE) && !lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q      <= '0;
      disp_q     <= '0;
      dbank_q    <= '0;
      lock_q     <= 1'b0;
      cbank_q    <= '0;
      cwe_q      <= 1'b0;
      cram_q     <= 1'b0;
      view_q     <= 1'b0;
      vmode_we_q <= 1'b0;
      vmode_q    <= '0;
    end else begin
      vmode_we_q <= wr_vm;
      if (wr_sys)  sys_q  <= sys_cfg_t'(wdata);
      if (wr_disp) disp_q <= disp_cfg_t'(wdata);
      if (wr_dbank) begin
        lock_q  <= wdata[7];
        dbank_q <= wdata[BANK_W-1:0];
      end
      if (wr_cbank) begin
        cwe_q   <= wdata[6];
        cram_q  <= wdata[5];
        cbank_q <= wdata[BANK_W-1:0];
      end
      if (wr_sw) view_q <= wdata[0];
      if (wr_vm) vmode_q <= wdata;
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int BANK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic              view,
  input  disp_cfg_t         disp,
  input  logic [BANK_W-1:0] dbank,
  input  logic [BANK_W-1:0] cbank,
  input  logic              cwe,
  input  logic              cram,
  input  logic [DW-1:0]     pen_data,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] ext_view;
  logic [DW-1:0] disp_bits;

  always_comb begin
    disp_bits = DW'(disp);
    unique case (sel)
      SEL_SWITCH: ext_view = {disp_bits[7:4], 4'b0000};
      SEL_DBANK:  ext_view = DW'(dbank);
      SEL_CBANK:  ext_view = {1'b0, cwe, cram, 5'(cbank)};
      default:    ext_view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (!rd_en) rd_data <= '0;
    else if (view)   rd_data <= pen_data;
    else             rd_data <= ext_view;
  end
endmodule

// File: rtl/sysctl_win.sv
module sysctl_win #(
  parameter int              CPU_AW  = 16,
  parameter int              HALF_AW = 13,
  parameter int              BANK_W  = 5,
  parameter logic [15:0]     BASE    = 16'h0000,
  parameter bit              SWAP    = 1'b0,
  localparam int             PA_W    = BANK_W + 1 + HALF_AW
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic              enable,
  input  logic [BANK_W-1:0] bank,
  output logic              hit,
  output logic [PA_W-1:0]   phys
);
  logic [CPU_AW-1:0] base_v;
  logic [CPU_AW-1:0] off;
  logic              half;

  always_comb begin
    base_v = CPU_AW'(BASE);
    off    = addr - base_v;
    hit    = enable && (addr >= base_v) && (off[CPU_AW-1:HALF_AW+1] == '0);
    half   = SWAP ? ~off[HALF_AW] : off[HALF_AW];
    phys   = {bank, half, off[HALF_AW-1:0]};
  end
endmodule

// File: rtl/sysctl_addrmap.sv
module sysctl_addrmap #(
  parameter int          CPU_AW    = 16,
  parameter int          HALF_AW   = 13,
  parameter int          BANK_W    = 5,
  parameter logic [15:0] CART_BASE = 16'h0000,
  parameter logic [15:0] DATA_BASE = 16'hA000,
  localparam int         PA_W      = BANK_W + 1 + HALF_AW,
  localparam int         NWIN      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cart_en,
  input  logic              data_en,
  input  logic [BANK_W-1:0] cbank,
  input  logic [BANK_W-1:0] dbank,
  input  logic              cwe,
  output logic              hit_q,
  output logic              wr_ok_q,
  output logic [PA_W-1:0]   phys_q
);
  logic [NWIN-1:0]   w_hit;
  logic [PA_W-1:0]   w_phys [NWIN];
  logic [NWIN-1:0]   w_en;
  logic [BANK_W-1:0] w_bank [NWIN];

  always_comb begin
    w_en[0]   = cart_en;
    w_bank[0] = cbank;
    w_en[1]   = data_en;
    w_bank[1] = dbank;
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    sysctl_win #(
      .CPU_AW (CPU_AW),
      .HALF_AW(HALF_AW),
      .BANK_W (BANK_W),
      .BASE   (g == 0 ? CART_BASE : DATA_BASE),
      .SWAP   (g == 1)
    ) u_win (
      .addr  (cpu_addr),
      .enable(w_en[g]),
      .bank  (w_bank[g]),
      .hit   (w_hit[g]),
      .phys  (w_phys[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      wr_ok_q <= 1'b0;
      phys_q  <= '0;
    end else if (w_hit[0]) begin
      hit_q   <= 1'b1;
      wr_ok_q <= cwe;
      phys_q  <= w_phys[0];
    end else if (w_hit[1]) begin
      hit_q   <= 1'b1;
      wr_ok_q <= 1'b1;
      phys_q  <= w_phys[1];
    end else begin
      hit_q   <= 1'b0;
      wr_ok_q <= 1'b0;
      phys_q  <= '0;
    end
  end
endmodule

// File: rtl/sysctl_bank_regs.sv
module sysctl_bank_regs
  import sysctl_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter int          HALF_AW   = 13,
  parameter int          BANK_W    = 5,
  parameter logic [15:0] CART_BASE = 16'h0000,
  parameter logic [15:0] DATA_BASE = 16'hA000,
  localparam int         PA_W      = BANK_W + 1 + HALF_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [DW-1:0]     pen_data,
  output logic [DW-1:0]     rd_data,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic              map_hit,
  output logic              map_wr_ok,
  output logic [PA_W-1:0]   phys_addr,
  output logic              ext_fdc,
  output logic              lines525,
  output logic              cart_bank_en,
  output logic              data_bank_en,
  output logic [1:0]        machine_type,
  output logic [1:0]        ram_type,
  output logic [1:0]        disp_page,
  output logic              cart_off,
  output logic              rom_sel,
  output logic [3:0]        border,
  output logic              cart_wr_en,
  output logic              cart_ram_sel,
  output logic              vmode_we,
  output logic [DW-1:0]     vmode_data
);
  sys_cfg_t          sys_q;
  disp_cfg_t         disp_q;
  logic [BANK_W-1:0] dbank_q;
  logic [BANK_W-1:0] cbank_q;
  logic              dbank_lock;
  logic              view_q;

  sysctl_regfile #(.BANK_W(BANK_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .sel       (reg_sel),
    .wdata     (wr_data),
    .sys_q     (sys_q),
    .disp_q    (disp_q),
    .dbank_q   (dbank_q),
    .lock_q    (dbank_lock),
    .cbank_q   (cbank_q),
    .cwe_q     (cart_wr_en),
    .cram_q    (cart_ram_sel),
    .view_q    (view_q),
    .vmode_we_q(vmode_we),
    .vmode_q   (vmode_data)
  );

  sysctl_rdmux #(.BANK_W(BANK_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .sel     (reg_sel),
    .view    (view_q),
    .disp    (disp_q),
    .dbank   (dbank_q),
    .cbank   (cbank_q),
    .cwe     (cart_wr_en),
    .cram    (cart_ram_sel),
    .pen_data(pen_data),
    .rd_data (rd_data)
  );

  sysctl_addrmap #(
    .CPU_AW   (CPU_AW),
    .HALF_AW  (HALF_AW),
    .BANK_W   (BANK_W),
    .CART_BASE(CART_BASE),
    .DATA_BASE(DATA_BASE)
  ) u_map (
    .clk     (clk),
    .rst     (rst),
    .cpu_addr(cpu_addr),
    .cart_en (sys_q.cart_bank_en && cart_ram_sel),
    .data_en (sys_q.data_bank_en),
    .cbank   (cbank_q),
    .dbank   (dbank_q),
    .cwe     (cart_wr_en),
    .hit_q   (map_hit),
    .wr_ok_q (map_wr_ok),
    .phys_q  (phys_addr)
  );

  always_comb begin
    ext_fdc      = sys_q.ext_fdc;
    lines525     = sys_q.lines525;
    cart_bank_en = sys_q.cart_bank_en;
    data_bank_en = sys_q.data_bank_en;
    machine_type = sys_q.machine;
    ram_type     = sys_q.ram_type;
    disp_page    = disp_q.page;
    cart_off     = disp_q.cart_off;
    rom_sel      = disp_q.rom_sel;
    border       = disp_q.border;
  end
endmodule

// File: rtl/sysctl_bank_regs_chk.sv
module sysctl_bank_regs_chk #(
  parameter int SEL_W  = 3,
  parameter int BANK_W = 5,
  parameter int PA_W   = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  reg_sel,
  input logic              rd_en,
  input logic [7:0]        pen_data,
  input logic [7:0]        rd_data,
  input logic              map_hit,
  input logic              map_wr_ok,
  input logic [PA_W-1:0]   phys_addr,
  input logic              cart_bank_en,
  input logic              data_bank_en,
  input logic              cart_ram_sel,
  input logic              cart_wr_en,
  input logic              vmode_we,
  input logic              dbank_lock,
  input logic              view_q,
  input logic [BANK_W-1:0] cbank_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !map_hit && !map_wr_ok && !vmode_we));

  // R5
  vmode_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    (vmode_we && $past(!rst)) |-> $past(wr_en && reg_sel == 3'd5 && !dbank_lock));

  // R5
  lock_blocks_vmode_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 3'd5 && dbank_lock) |=> !vmode_we);

  // R6
  cart_protect_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 3'd2 && !cart_bank_en)
      |=> ($stable(cbank_q) && $stable(cart_wr_en) && $stable(cart_ram_sel)));

  // R7
  pen_view_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_en && view_q)) |-> (rd_data == $past(pen_data)));

  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rd_en)) |-> (rd_data == '0));

  // R9
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (map_hit && $past(!rst)) |-> $past(data_bank_en || (cart_bank_en && cart_ram_sel)));

  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !map_hit |-> (!map_wr_ok && phys_addr == '0));
endmodule

bind sysctl_bank_regs sysctl_bank_regs_chk #(
  .SEL_W (3),
  .BANK_W(BANK_W),
  .PA_W  (PA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .reg_sel     (reg_sel),
  .rd_en       (rd_en),
  .pen_data    (pen_data),
  .rd_data     (rd_data),
  .map_hit     (map_hit),
  .map_wr_ok   (map_wr_ok),
  .phys_addr   (phys_addr),
  .cart_bank_en(cart_bank_en),
  .data_bank_en(data_bank_en),
  .cart_ram_sel(cart_ram_sel),
  .cart_wr_en  (cart_wr_en),
  .vmode_we    (vmode_we),
  .dbank_lock  (dbank_lock),
  .view_q      (view_q),
  .cbank_q     (cbank_q)
);

// File: tb/sysctl_bank_regs_tb.sv
module sysctl_bank_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_sel = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  pen_data = '0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  rd_data;
  logic        map_hit, map_wr_ok;
  logic [18:0] phys_addr;
  logic        ext_fdc, lines525, cart_bank_en, data_bank_en;
  logic [1:0]  machine_type, ram_type, disp_page;
  logic        cart_off, rom_sel, cart_wr_en, cart_ram_sel, vmode_we;
  logic [3:0]  border;
  logic [7:0]  vmode_data;

  always #4 clk = ~clk;

  sysctl_bank_regs u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .pen_data(pen_data), .rd_data(rd_data), .cpu_addr(cpu_addr),
    .map_hit(map_hit), .map_wr_ok(map_wr_ok), .phys_addr(phys_addr),
    .ext_fdc(ext_fdc), .lines525(lines525), .cart_bank_en(cart_bank_en),
    .data_bank_en(data_bank_en), .machine_type(machine_type), .ram_type(ram_type),
    .disp_page(disp_page), .cart_off(cart_off), .rom_sel(rom_sel), .border(border),
    .cart_wr_en(cart_wr_en), .cart_ram_sel(cart_ram_sel), .vmode_we(vmode_we),
    .vmode_data(vmode_data)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  m_sys, m_disp, m_vq;
  logic [4:0]  m_dbank, m_cbank;
  logic        m_lock, m_cwe, m_cram, m_view;
  logic [7:0]  e_rd;
  logic        e_hit, e_wok, e_vwe;
  logic [18:0] e_phys;
  string       e_rd_tag, e_map_tag;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_sys = 0; m_disp = 0; m_vq = 0; m_dbank = 0; m_cbank = 0;
      m_lock = 0; m_cwe = 0; m_cram = 0; m_view = 0;
      e_rd = 0; e_hit = 0; e_wok = 0; e_vwe = 0; e_phys = 0;
      e_rd_tag = "R1"; e_map_tag = "R1";
    end else begin
      // read path
      if (!rd_en) begin e_rd = 0; e_rd_tag = "R7"; end
      else if (m_view) begin e_rd = pen_data; e_rd_tag = "R7"; end
      else begin
        case (reg_sel)
          3'd0: begin e_rd = {m_disp[7:4], 4'h0}; e_rd_tag = "R8"; end
          3'd1: begin e_rd = {3'b000, m_dbank}; e_rd_tag = "R4"; end
          3'd2: begin e_rd = {1'b0, m_cwe, m_cram, m_cbank}; e_rd_tag = "R6"; end
          default: begin e_rd = 0; e_rd_tag = "R8"; end
        endcase
      end
      // address map
      if (m_sys[6] && m_cram && cpu_addr < 16'h4000) begin
        e_hit = 1; e_wok = m_cwe;
        e_phys = {m_cbank, cpu_addr[13], cpu_addr[12:0]};
        e_map_tag = "R10";
      end else if (m_sys[4] && cpu_addr >= 16'hA000 && cpu_addr < 16'hE000) begin
        logic [15:0] off;
        off = cpu_addr - 16'hA000;
        e_hit = 1; e_wok = 1;
        e_phys = {m_dbank, ~off[13], off[12:0]};
        e_map_tag = "R9";
      end else begin
        e_hit = 0; e_wok = 0; e_phys = 0; e_map_tag = "R11";
      end
      // writes
      e_vwe = wr_en && reg_sel == 3'd5 && !m_lock;
      if (e_vwe) m_vq = wr_data;
      if (wr_en) begin
        case (reg_sel)
          3'd0: m_view = wr_data[0];
          3'd1: begin m_lock = wr_data[7]; m_dbank = wr_data[4:0]; end
          3'd2: if (m_sys[6]) begin
                  m_cwe = wr_data[6]; m_cram = wr_data[5]; m_cbank = wr_data[4:0];
                end
          3'd3: m_sys = wr_data;
          3'd4: m_disp = wr_data;
          default: ;
        endcase
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk({e_rd_tag, " rd_data"}, rd_data, e_rd);
      chk({e_map_tag, " map_hit"}, map_hit, e_hit);
      chk({e_map_tag, " map_wr_ok"}, map_wr_ok, e_wok);
      chk({e_map_tag, " phys_addr"}, phys_addr, e_phys);
      chk("R2 sys fields", {ext_fdc, cart_bank_en, lines525, data_bank_en, machine_type, ram_type}, m_sys);
      chk("R3 disp fields", {disp_page, cart_off, rom_sel, border}, m_disp);
      chk("R5 vmode_we", vmode_we, e_vwe);
      chk("R5 vmode_data", vmode_data, m_vq);
      chk("R6 cart fields", {cart_wr_en, cart_ram_sel}, {m_cwe, m_cram});
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  int          aidx = 0;
  logic [15:0] edges [12] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'h9FFF,
                              16'hA000, 16'hBFFF, 16'hC000, 16'hDFFF, 16'hE000, 16'hFFFF};

  task automatic next_addr();
    if (aidx < 12) cpu_addr = edges[aidx];
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cpu_addr = lfsr;
    end
    aidx = (aidx + 1) % 24;
    pen_data = pen_data + 8'h3B;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; rd_en = 0; reg_sel = s; wr_data = d; next_addr();
  endtask

  task automatic rd(input logic [2:0] s);
    @(negedge clk);
    wr_en = 0; rd_en = 1; reg_sel = s; wr_data = 8'hFF; next_addr();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 0; rd_en = 0; next_addr();
    end
  endtask

  task automatic read_all();
    for (int s = 0; s < 8; s++) rd(3'(s));
  endtask

  initial begin : watchdog
    wait (cycles > 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 explicit reset state
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset map_hit", map_hit, 0);
    chk("R1 reset border", border, 0);
    chk("R1 reset vmode_we", vmode_we, 0);
    read_all();
    wr(3'd5, 8'h5A);                 // R5 unlocked write
    wr(3'd2, 8'h7F);                 // R6 ignored, banking off
    rd(3'd2);
    wr(3'd3, 8'hFF);                 // R2 all set
    wr(3'd2, 8'hE3);                 // R6 accepted, bit 7 dropped
    rd(3'd2);
    wr(3'd1, 8'hFF);                 // R4 lock on, bank 31
    rd(3'd1);
    wr(3'd5, 8'hC3);                 // R5 blocked
    idle(2);
    wr(3'd1, 8'h65);                 // R4 unlock, bits 6:5 dropped
    rd(3'd1);
    wr(3'd5, 8'h96);                 // R5 accepted
    wr(3'd4, 8'hD7);                 // R3
    read_all();                      // R8
    wr(3'd0, 8'h01);                 // R7 lightpen view
    read_all();
    wr(3'd0, 8'hFE);
    read_all();
    wr(3'd2, 8'h2A);                 // RAM, read-only
    idle(48);                        // R9 R10 sweep
    wr(3'd2, 8'h75);
    idle(48);
    wr(3'd2, 8'h45);                 // ROM in cartridge window
    idle(30);
    wr(3'd3, 8'h2D);                 // banking off R11
    wr(3'd2, 8'h7F);                 // R6 ignored again
    rd(3'd2);
    idle(30);
    wr(3'd3, 8'h50);
    wr(3'd1, 8'h11);
    idle(30);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule